// File: doc/BRIEF.md
# Sub-blocked direct-mapped write-back cache

This block is a direct-mapped data cache placed between a processor request port and a simple sub-block wide memory port. Every line stores one tag, a dirty flag and a separate valid flag for each of its sub-blocks. A request splits its byte address into tag, line index and byte select. It is a hit when the stored tag of the indexed line matches and the addressed sub-block is valid. A hit is answered in the same cycle as the request: read data returns at once, and write data is merged into the line.

On a miss the controller fetches only the addressed sub-block. If the line currently holds a different tag and is dirty, its valid sub-blocks are first written back in ascending order. Writes are write-back and write-allocate. A write miss fetches the sub-block, then merges the word and marks the line dirty. The processor holds its request until `cpu_ready` is high, which stalls it for the duration of a miss.

Top module: `sbcache`

## Requirements
- R1: After a synchronous active-high reset every sub-block of every line is invalid: `cpu_ready` and `mem_req` are low with no request, and the first access to any address misses and reads memory.
- R2: The 32-bit byte address decodes as bits 31:10 tag, bits 9:5 line index, bits 4:3 sub-block, bit 2 word within the sub-block (bits 1:0 ignored). Two addresses with the same index and different tags evict each other.
- R3: A request whose tag matches and whose sub-block is valid raises `cpu_ready` in the same cycle as `cpu_req`, and `cpu_rdata` carries the stored 32-bit word (word 0 = sub-block bits 31:0, word 1 = bits 63:32).
- R4: A miss issues exactly one memory read (`mem_we`=0) at the sub-block aligned address (address with bits 2:0 cleared). The request then completes with the fetched data.
- R5: A fill validates only the addressed sub-block; other sub-blocks of the line keep their state. A miss on an invalid sub-block of a line with a matching tag reads only that sub-block and writes nothing back.
- R6: A write hit updates only the cache with no memory transfer, marks the line dirty, and later reads return the new word.
- R7: A write miss fetches the addressed sub-block, merges the write word into it, and a later read of the other word returns memory data.
- R8: Replacing a dirty line with a different tag first writes each valid sub-block (`mem_we`=1, full 64-bit data, at its old address) in ascending sub-block order, skipping invalid ones. The refill read is issued afterwards.
- R9: Replacing a clean line issues no write-back.
- R10: When a fill changes a line's tag, all other sub-blocks of that line become invalid.
- R11: While a miss is outstanding `cpu_ready` stays low, and `mem_req`, `mem_we`, `mem_addr` and write data hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| mem_req | output | 1 | Memory transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Sub-block aligned byte address |
| mem_wdata | output | 64 | Write-back sub-block data |
| mem_ack | input | 1 | One-cycle completion of the current transfer |
| mem_rdata | input | 64 | Refill data, valid with mem_ack |

## Verification
The bench builds the block with its default geometry: 1 KB, 32-byte lines, 8-byte sub-blocks and 32-bit words. That makes 32 lines of four sub-blocks, so a dirty victim can need one to four write-back beats. The top index 31 and the tag boundary at bit 10 can be reached by direct addresses. The memory model answers after three cycles, which exposes the hold-until-acknowledge behaviour on every transfer. A random mix over four tags and four indices drives partial lines, same-tag refills and dirty evictions against the reference model.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_t;

    function automatic logic is_last(input int unsigned pos, input int unsigned count);
        return pos == count - 1;
    endfunction

endpackage

// File: rtl/sbc_tags.sv
module sbc_tags #(
    parameter int LINES = 32,
    parameter int TAG_W = 22,
    parameter int NSUB  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(LINES)-1:0] idx,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [NSUB-1:0]          rd_valid,
    output logic                     rd_dirty,
    input  logic                     fill_we,
    input  logic [$clog2(NSUB)-1:0]  fill_sub,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic                     mark_dirty
);
    localparam int IDX_W = $clog2(LINES);
    localparam int SEL_W = $clog2(NSUB);

    logic [TAG_W-1:0] tag_q   [LINES];
    logic [NSUB-1:0]  valid_q [LINES];
    logic             dirty_q [LINES];
    logic [NSUB-1:0]  sub_bit;

    assign sub_bit  = NSUB'(1) << fill_sub;
    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]   <= '0;
                valid_q[i] <= '0;
                dirty_q[i] <= 1'b0;
            end
        end else begin
            if (fill_we) begin
                if (tag_q[idx] != fill_tag) begin
                    tag_q[idx]   <= fill_tag;
                    valid_q[idx] <= sub_bit;
                    dirty_q[idx] <= 1'b0;
                end else begin
                    valid_q[idx] <= valid_q[idx] | sub_bit;
                end
            end
            if (mark_dirty) dirty_q[idx] <= 1'b1;
        end
    end

    // checker state: remembers the last fill for the next-cycle properties
    logic             chk_fill;
    logic             chk_newtag;
    logic [IDX_W-1:0] chk_idx;
    logic [SEL_W-1:0] chk_sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_fill   <= 1'b0;
            chk_newtag <= 1'b0;
            chk_idx    <= '0;
            chk_sub    <= '0;
        end else begin
            chk_fill   <= fill_we;
            chk_newtag <= tag_q[idx] != fill_tag;
            chk_idx    <= idx;
            chk_sub    <= fill_sub;
        end
    end

    p_fill_sets_valid_r4: assert property (@(posedge clk) disable iff (rst)
        chk_fill |-> valid_q[chk_idx][chk_sub]);

    p_tag_change_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (chk_fill && chk_newtag) |-> $countones(valid_q[chk_idx]) == 1);

    p_dirty_means_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rd_dirty |-> (rd_valid != '0));

endmodule

// File: rtl/sbc_data.sv
module sbc_data #(
    parameter int LINES  = 32,
    parameter int NSUB   = 4,
    parameter int SUB_W  = 64,
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic [$clog2(LINES)-1:0]          idx,
    input  logic [$clog2(NSUB)-1:0]           rd_sub,
    output logic [SUB_W-1:0]                  rd_data,
    input  logic [$clog2(NSUB)-1:0]           wb_sub,
    output logic [SUB_W-1:0]                  wb_data,
    input  logic                              fill_we,
    input  logic [SUB_W-1:0]                  fill_data,
    input  logic                              word_we,
    input  logic [$clog2(SUB_W/DATA_W)-1:0]   word_sel,
    input  logic [DATA_W-1:0]                 word_data
);
    logic [SUB_W-1:0] store_q [LINES][NSUB];

    assign rd_data = store_q[idx][rd_sub];
    assign wb_data = store_q[idx][wb_sub];

    always_ff @(posedge clk) begin
        if (fill_we)
            store_q[idx][rd_sub] <= fill_data;
        else if (word_we)
            store_q[idx][rd_sub][word_sel*DATA_W +: DATA_W] <= word_data;
    end

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int NSUB = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic                    hit,
    input  logic                    tag_match,
    input  logic                    line_dirty,
    input  logic [NSUB-1:0]         line_valid,
    input  logic                    mem_ack,
    output logic                    cpu_ready,
    output logic                    word_we,
    output logic                    fill_we,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic                    wb_phase,
    output logic [$clog2(NSUB)-1:0] wb_sub
);
    localparam int SEL_W = $clog2(NSUB);

    ctl_state_t       state_q, state_d;
    logic [SEL_W-1:0] wb_q, wb_d;
    logic             beat_done;

    assign wb_sub    = wb_q;
    assign wb_phase  = state_q == ST_WBACK;
    assign beat_done = !line_valid[wb_q] || mem_ack;

    always_comb begin
        state_d   = state_q;
        wb_d      = wb_q;
        cpu_ready = 1'b0;
        fill_we   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_ready = 1'b1;
                    end else if (!tag_match && line_dirty) begin
                        state_d = ST_WBACK;
                        wb_d    = '0;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req = line_valid[wb_q];
                mem_we  = 1'b1;
                if (beat_done) begin
                    if (is_last(int'(wb_q), NSUB)) state_d = ST_FILL;
                    else                           wb_d    = wb_q + 1'b1;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_we = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign word_we = cpu_ready && cpu_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wb_q    <= '0;
        end else begin
            state_q <= state_d;
            wb_q    <= wb_d;
        end
    end

endmodule

// File: rtl/sbcache.sv
module sbcache #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 1024,
    parameter int LINE_BYTES  = 32,
    parameter int SUB_BYTES   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic                  cpu_ready,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [SUB_BYTES*8-1:0] mem_wdata,
    input  logic                  mem_ack,
    input  logic [SUB_BYTES*8-1:0] mem_rdata
);
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int NSUB   = LINE_BYTES / SUB_BYTES;
    localparam int SUB_W  = SUB_BYTES * 8;
    localparam int WB_W   = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(SUB_W / DATA_W);
    localparam int SEL_W  = $clog2(NSUB);
    localparam int SOFF_W = $clog2(SUB_BYTES);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic [TAG_W-1:0]  a_tag, rd_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [SEL_W-1:0]  a_sub, wb_sub;
    logic [WSEL_W-1:0] a_word;
    logic [NSUB-1:0]   rd_valid;
    logic              rd_dirty, tag_match, hit;
    logic              word_we, fill_we, wb_phase;
    logic [SUB_W-1:0]  rd_data, wb_data;
    logic              byte_unused;

    assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx       = cpu_addr[OFF_W +: IDX_W];
    assign a_sub       = cpu_addr[SOFF_W +: SEL_W];
    assign a_word      = cpu_addr[WB_W +: WSEL_W];
    assign byte_unused = ^cpu_addr[WB_W-1:0];

    assign tag_match = rd_tag == a_tag;
    assign hit       = tag_match && rd_valid[a_sub];
    assign cpu_rdata = rd_data[a_word*DATA_W +: DATA_W];
    assign mem_wdata = wb_data;
    assign mem_addr  = wb_phase ? {rd_tag, a_idx, wb_sub, {SOFF_W{1'b0}}}
                                : {a_tag,  a_idx, a_sub,  {SOFF_W{1'b0}}};

    sbc_tags #(.LINES(LINES), .TAG_W(TAG_W), .NSUB(NSUB)) u_tags (
        .clk(clk), .rst(rst), .idx(a_idx),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .fill_we(fill_we), .fill_sub(a_sub), .fill_tag(a_tag),
        .mark_dirty(word_we)
    );

    sbc_data #(.LINES(LINES), .NSUB(NSUB), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .idx(a_idx), .rd_sub(a_sub), .rd_data(rd_data),
        .wb_sub(wb_sub), .wb_data(wb_data),
        .fill_we(fill_we), .fill_data(mem_rdata),
        .word_we(word_we), .word_sel(a_word), .word_data(cpu_wdata)
    );

    sbc_ctrl #(.NSUB(NSUB)) u_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .hit(hit), .tag_match(tag_match), .line_dirty(rd_dirty),
        .line_valid(rd_valid), .mem_ack(mem_ack),
        .cpu_ready(cpu_ready), .word_we(word_we), .fill_we(fill_we),
        .mem_req(mem_req), .mem_we(mem_we), .wb_phase(wb_phase), .wb_sub(wb_sub)
    );

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (!mem_we || $stable(mem_wdata))));

    p_ready_excl_r11: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

endmodule

// File: tb/sbcache_tb.sv
module sbcache_tb;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    logic [96:0] expq [$];
    logic [63:0] bmem [int unsigned];
    logic [21:0] mtag  [32];
    logic [3:0]  mval  [32];
    bit          mdirty[32];
    logic [63:0] mdata [32][4];

    always #5 clk = ~clk;

    sbcache u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] mem_val(input logic [31:0] a);
        if (bmem.exists(a)) return bmem[a];
        return {a ^ 32'hC3C3_0000, ~a};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // memory model: acknowledges each transfer LAT cycles after it starts
    initial begin
        int cnt = 0;
        logic [96:0] e;
        forever begin
            @(negedge clk);
            #2;
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req && !rst) begin
                cnt++;
                if (cnt >= LAT) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R6", "unexpected memory transfer", 64'(mem_addr), 64'h0);
                    end else begin
                        e = expq.pop_front();
                        if (mem_we)
                            chk(e[96] && e[95:64] == mem_addr && e[63:0] == mem_wdata, "R8",
                                "write-back transfer", {mem_addr, mem_wdata[31:0]},
                                {e[95:64], e[31:0]});
                        else
                            chk(!e[96] && e[95:64] == mem_addr, "R4", "refill read",
                                {31'h0, mem_we, mem_addr}, {31'h0, e[96], e[95:64]});
                    end
                    if (mem_we) bmem[mem_addr] = mem_wdata;
                    mem_rdata = mem_val(mem_addr);
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          input string tag);
        int          idx = int'(a[9:5]);
        int          sb  = int'(a[4:3]);
        int          w   = int'(a[2]);
        logic [21:0] tg  = a[31:10];
        bit          hit;
        logic [31:0] exp;
        hit = mval[idx][sb] && mtag[idx] == tg;
        if (!hit) begin
            if (mtag[idx] != tg) begin
                if (mdirty[idx])
                    for (int s = 0; s < 4; s++)
                        if (mval[idx][s])
                            expq.push_back({1'b1, mtag[idx], 5'(idx), 2'(s), 3'b000,
                                            mdata[idx][s]});
                mval[idx]   = 4'b0000;
                mdirty[idx] = 1'b0;
                mtag[idx]   = tg;
            end
            expq.push_back({1'b0, a[31:3], 3'b000, 64'h0});
            mdata[idx][sb] = mem_val({a[31:3], 3'b000});
            mval[idx][sb]  = 1'b1;
        end
        if (we) begin
            mdata[idx][sb][w*32 +: 32] = wd;
            mdirty[idx] = 1'b1;
        end
        exp = mdata[idx][sb][w*32 +: 32];

        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        chk(cpu_ready == hit, hit ? "R3" : "R11", "ready in first request cycle",
            64'(cpu_ready), 64'(hit));
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        if (!we) chk(cpu_rdata == exp, tag, "read data", 64'(cpu_rdata), 64'(exp));
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        chk(expq.size() == 0, tag, "all expected memory transfers issued",
            64'(expq.size()), 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r = 16'hACE1;
        for (int i = 0; i < 32; i++) begin
            mtag[i] = '0; mval[i] = '0; mdirty[i] = 1'b0;
            for (int s = 0; s < 4; s++) mdata[i][s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "idle outputs after reset",
            {62'h0, cpu_ready, mem_req}, 64'h0);

        access(1'b0, 32'h0000_0000, 32'h0, "R1");         // cold miss
        access(1'b0, 32'h0000_0004, 32'h0, "R3");         // hit, upper word
        access(1'b0, 32'h0000_0008, 32'h0, "R5");         // other sub-block still invalid
        access(1'b1, 32'h0000_0010, 32'hDEAD_0010, "R7"); // write miss allocates
        access(1'b0, 32'h0000_0014, 32'h0, "R7");         // neighbour word from memory
        access(1'b0, 32'h0000_0010, 32'h0, "R7");
        access(1'b1, 32'h0000_0000, 32'h1234_5678, "R6"); // write hit, no transfer
        access(1'b0, 32'h0000_0000, 32'h0, "R6");
        access(1'b0, 32'h0000_0400, 32'h0, "R8");         // dirty victim subs 0,1,2
        access(1'b0, 32'h0000_0408, 32'h0, "R10");        // old tag's sub 1 gone
        access(1'b0, 32'h0000_0008, 32'h0, "R9");         // clean victim
        access(1'b1, 32'h0000_001C, 32'hBEEF_001C, "R5"); // same tag, sub 3
        access(1'b0, 32'h0000_0800, 32'h0, "R8");         // write back subs 1 and 3 only
        access(1'b0, 32'h0000_03FC, 32'h0, "R2");         // top index, last word
        access(1'b1, 32'h0000_07FC, 32'h7777_07FC, "R2"); // same index, other tag
        access(1'b0, 32'h0000_03FC, 32'h0, "R2");
        access(1'b0, 32'h0000_07FC, 32'h0, "R2");

        for (int n = 0; n < 200; n++) begin
            logic [31:0] a;
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            a = {20'h0, r[1:0], r[3:2] == 2'b11 ? 5'd31 : {3'b000, r[3:2]}, r[5:4], r[6], 2'b00};
            access(r[7], a, {r, ~r}, "R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule